// File: doc/BRIEF.md
# Multi-Core Block Dispatcher with In-Order Return

This block fans a byte-serial stream of 16-byte blocks out over a compile-time number of identical byte-serial processing cores. It then gathers the results back onto a single byte-wide output. Every core takes one whole block and returns a whole block after a fixed delay. That delay depends on the operating mode of the cores: 99, 119 or 139 cycles for the three key lengths of the cipher that normally fills these slots. The dispatcher itself never looks at the data. It picks a free core for each new block, remembers the order in which blocks were handed out, and forwards the result bytes strictly in that order.

The upstream side is a valid/ready stream. A byte moves on every cycle where `in_valid` and `in_ready` are both high. `in_ready` goes low only at a block boundary when every core is occupied. Once the first byte of a block has been taken, the remaining fifteen are always accepted. The source has to insert at least one cycle with `in_valid` low after each sixteenth byte. The core-facing side and the output carry a valid flag only. The cores cannot be stalled, so the output has no back-pressure.

With enough cores and a source that sends a block every 17 cycles, the output settles to 16 valid bytes followed by one idle cycle, block after block.

Top module: `blk_dispatcher`

## Requirements
- R1: Each block of 16 accepted input bytes is delivered, byte for byte and in order on `core_in_data`, to a single core. That core's bit of `core_in_valid` is high exactly on those 16 acceptance cycles.
- R2: At the first byte of a block, the dispatcher chooses the free core with the lowest index.
- R3: A core counts as occupied from the cycle its first input byte is accepted until the cycle its sixteenth result byte is taken. `in_ready` is high whenever a block is in progress or at least one core is free.
- R4: Result blocks leave on `out_data` in the same order their input blocks were accepted, whichever cores carried them.
- R5: Output is registered. `out_valid`/`out_data` repeat, one cycle later, the valid and data of the core whose result is due next.
- R6: With 11 cores and core delays of 99, 119 or 139 cycles, a source sending one block every 17 cycles is never stalled. After the first result, a new result block starts every 17 cycles.
- R7: When every core is occupied at a block boundary, `in_ready` is low. The waiting block is taken once a core frees, and ordering still holds.
- R8: A synchronous active-high `rst` frees all cores and forgets all pending results. After reset, `in_ready` is high, `out_valid` is low and the next block goes to core 0.
- R9: After the first byte of a block is accepted, `in_ready` stays high for the other 15 bytes, even if every core is now occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Dispatcher can take a byte |
| core_in_valid | output | NCORES | Per-core input strobe, one-hot when active |
| core_in_data | output | 8 | Byte broadcast to all cores |
| core_out_valid | input | NCORES | Per-core result valid |
| core_out_data | input | 8*NCORES | Per-core result bytes, core i at bits 8i+7..8i |
| out_valid | output | 1 | Result byte valid |
| out_data | output | 8 | Result byte |

## Verification
The bench builds the block with its default of 11 cores. It stands in behavioural cores whose delay is a run-time variable, so one build covers the three mode delays at the 17-cycle input rate. A fourth, deliberately excessive delay of 300 cycles exhausts the 11 cores. That brings the stalled-boundary case, the mid-block readiness rule and out-of-core waiting within reach without a second build. A reset issued while most cores still hold blocks shows that pending results are dropped and that dispatch restarts at core 0.

// File: rtl/blk_disp_pkg.sv
package blk_disp_pkg;
  localparam int BYTE_W    = 8;
  localparam int BLK_BYTES = 16;
  localparam int BEAT_W    = $clog2(BLK_BYTES);
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/blk_free_pick.sv
// Lowest-index selection among free cores.
module blk_free_pick #(
  parameter int N  = 11,
  parameter int IW = 4
) (
  input  logic [N-1:0]  free_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |free_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/blk_order_fifo.sv
// Records the core index of each dispatched block, in dispatch order.
module blk_order_fifo #(
  parameter int DEPTH = 11,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign data_o  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem[wr_q] <= data_i;
        wr_q      <= (wr_q == LAST) ? '0 : wr_q + AW'(1);
      end
      if (pop_i) rd_q <= (rd_q == LAST) ? '0 : rd_q + AW'(1);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    push_i |-> (!full_o || pop_i));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);
endmodule

// File: rtl/blk_in_router.sv
// Accepts upstream bytes and steers each block to one core.
module blk_in_router
  import blk_disp_pkg::*;
#(
  parameter int N  = 11,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid_i,
  input  byte_t         in_data_i,
  output logic          in_ready_o,
  input  logic [N-1:0]  busy_i,
  output logic [N-1:0]  core_vld_o,
  output byte_t         core_data_o,
  output logic          start_o,
  output logic [IW-1:0] start_idx_o
);
  localparam beat_t LAST_BEAT = BEAT_W'(BLK_BYTES - 1);

  logic          mid_q;
  beat_t         beat_q;
  logic [IW-1:0] held_q;
  logic          any_free;
  logic [IW-1:0] pick;
  logic [IW-1:0] sel;
  logic          acc;

  blk_free_pick #(.N(N), .IW(IW)) u_pick (
    .free_i (~busy_i),
    .any_o  (any_free),
    .idx_o  (pick)
  );

  assign in_ready_o  = mid_q | any_free;
  assign acc         = in_valid_i & in_ready_o;
  assign start_o     = acc & ~mid_q;
  assign start_idx_o = pick;
  assign sel         = mid_q ? held_q : pick;
  assign core_data_o = in_data_i;

  for (genvar g = 0; g < N; g++) begin : g_vld
    assign core_vld_o[g] = acc && (sel == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q  <= 1'b0;
      beat_q <= '0;
      held_q <= '0;
    end else if (acc) begin
      if (start_o) held_q <= pick;
      if (beat_q == LAST_BEAT) begin
        mid_q  <= 1'b0;
        beat_q <= '0;
      end else begin
        mid_q  <= 1'b1;
        beat_q <= beat_q + BEAT_W'(1);
      end
    end
  end

  // Back-to-back strobes inside a block stay on one core (blocks are gap-separated).
  p_same_core_r1: assert property (@(posedge clk) disable iff (rst)
    ((core_vld_o != '0) && $past(core_vld_o != '0)) |-> (core_vld_o == $past(core_vld_o)));
  p_mid_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (acc && !start_o && beat_q != LAST_BEAT) |=> in_ready_o);
endmodule

// File: rtl/blk_out_merge.sv
// Forwards the result of the core whose block is due next.
module blk_out_merge
  import blk_disp_pkg::*;
#(
  parameter int N  = 11,
  parameter int IW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        core_vld_i,
  input  logic [N*BYTE_W-1:0] core_data_i,
  input  logic [IW-1:0]       head_i,
  input  logic                head_ok_i,
  output logic                out_valid_o,
  output byte_t               out_data_o,
  output logic                done_o
);
  localparam beat_t LAST_BEAT = BEAT_W'(BLK_BYTES - 1);

  logic  head_vld;
  beat_t beat_q;

  assign head_vld = head_ok_i & core_vld_i[head_i];
  assign done_o   = head_vld && (beat_q == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q      <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= head_vld;
      out_data_o  <= core_data_i[head_i*BYTE_W +: BYTE_W];
      if (head_vld) beat_q <= (beat_q == LAST_BEAT) ? '0 : beat_q + BEAT_W'(1);
    end
  end

  p_out_follows_r5: assert property (@(posedge clk) disable iff (rst)
    head_vld |=> out_valid_o);
  p_idle_follows_r5: assert property (@(posedge clk) disable iff (rst)
    !head_vld |=> !out_valid_o);
endmodule

// File: rtl/blk_dispatcher.sv
module blk_dispatcher
  import blk_disp_pkg::*;
#(
  parameter int NCORES = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  output logic                     in_ready,
  output logic [NCORES-1:0]        core_in_valid,
  output logic [7:0]               core_in_data,
  input  logic [NCORES-1:0]        core_out_valid,
  input  logic [NCORES*8-1:0]      core_out_data,
  output logic                     out_valid,
  output logic [7:0]               out_data
);
  localparam int IW = (NCORES > 1) ? $clog2(NCORES) : 1;

  logic [NCORES-1:0] busy_q, set_m, clr_m;
  logic              start, done, empty, full;
  logic [IW-1:0]     start_idx, head_idx;

  blk_in_router #(.N(NCORES), .IW(IW)) u_in (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .in_ready_o  (in_ready),
    .busy_i      (busy_q),
    .core_vld_o  (core_in_valid),
    .core_data_o (core_in_data),
    .start_o     (start),
    .start_idx_o (start_idx)
  );

  blk_order_fifo #(.DEPTH(NCORES), .W(IW)) u_order (
    .clk     (clk),
    .rst     (rst),
    .push_i  (start),
    .data_i  (start_idx),
    .pop_i   (done),
    .data_o  (head_idx),
    .empty_o (empty),
    .full_o  (full)
  );

  blk_out_merge #(.N(NCORES), .IW(IW)) u_out (
    .clk         (clk),
    .rst         (rst),
    .core_vld_i  (core_out_valid),
    .core_data_i (core_out_data),
    .head_i      (head_idx),
    .head_ok_i   (!empty),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .done_o      (done)
  );

  for (genvar g = 0; g < NCORES; g++) begin : g_busy
    assign set_m[g] = start && (start_idx == IW'(g));
    assign clr_m[g] = done && (head_idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= (busy_q | set_m) & ~clr_m;
  end

  p_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (&busy_q));
  p_dispatch_free_r3: assert property (@(posedge clk) disable iff (rst)
    start |-> ((core_in_valid & busy_q) == '0));
  p_lowest_r2: assert property (@(posedge clk) disable iff (rst)
    start |-> (((core_in_valid - NCORES'(1)) & ~busy_q) == '0));
  p_busy_keep_r3: assert property (@(posedge clk) disable iff (rst)
    !done |=> (($past(busy_q) & ~busy_q) == '0));
  p_busy_set_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> ((busy_q & $past(core_in_valid)) == $past(core_in_valid)));
endmodule

// File: tb/blk_dispatcher_tb.sv
module blk_dispatcher_tb;
  localparam int N = 11;
  localparam logic [7:0] XK = 8'h5C;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [7:0]      in_data = '0;
  logic            in_ready;
  logic [N-1:0]    core_in_valid;
  logic [7:0]      core_in_data;
  logic [N-1:0]    core_out_valid;
  logic [N*8-1:0]  core_out_data;
  logic            out_valid;
  logic [7:0]      out_data;

  logic [N-1:0]    mbusy;
  int lat = 99;
  int tests = 0, fails = 0;
  int cyc = 0;
  bit inblk = 0;
  bit streaming = 0;
  int low_cnt = 0;
  int last_start = 0;
  int oblk = 0;
  int obyte = 0;
  bit anyv_q = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;   // 250 MHz

  blk_dispatcher #(.NCORES(N)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .core_in_valid(core_in_valid), .core_in_data(core_in_data),
    .core_out_valid(core_out_valid), .core_out_data(core_out_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Behavioural cores: result byte = input byte ^ XK, delay lat after last input byte.
  for (genvar i = 0; i < N; i++) begin : g_core
    logic [7:0] mem [16];
    int icnt, timer, ocnt;
    logic v, b;
    logic [7:0] d;
    assign core_out_valid[i]       = v;
    assign core_out_data[i*8 +: 8] = d;
    assign mbusy[i]                = b;
    always @(posedge clk) begin
      if (rst) begin
        icnt <= 0; timer <= 0; ocnt <= 0; v <= 1'b0; b <= 1'b0; d <= '0;
      end else begin
        if (core_in_valid[i]) begin
          mem[icnt] <= core_in_data;
          b <= 1'b1;
          if (icnt == 15) begin icnt <= 0; timer <= lat; end
          else icnt <= icnt + 1;
        end
        if (timer > 0) begin
          timer <= timer - 1;
          if (timer == 1) begin v <= 1'b1; d <= mem[0] ^ XK; ocnt <= 1; end
        end else if (v) begin
          if (ocnt == 16) begin v <= 1'b0; b <= 1'b0; end
          else begin d <= mem[ocnt] ^ XK; ocnt <= ocnt + 1; end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    anyv_q <= |core_out_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (!mbusy[i]) return i;
    return -1;
  endfunction

  function automatic int onehot_idx(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  // Monitor: ready rule, registered output, scoreboard, spacing.
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      // R3 / R9 / R7: ready high iff in a block or some core is free
      if (in_ready !== (inblk || !(&mbusy)))
        check(0, "R3", in_ready, inblk || !(&mbusy));
      if (!in_ready) low_cnt++;
      // R5: output repeats the due core's valid one cycle later
      if (out_valid !== anyv_q) check(0, "R5", out_valid, anyv_q);
      if (out_valid) begin
        if (exp_q.size() == 0) check(0, "R4 (no result expected)", out_data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(out_data == e, "R4", out_data, e);
        end
        if (obyte == 0) begin
          if (streaming && oblk > 0) check(cyc - last_start == 17, "R6", cyc - last_start, 17);
          last_start = cyc;
          oblk++;
        end
        obyte = (obyte + 1) % 16;
      end
    end
  end

  task automatic send_block();
    int core0;
    logic [7:0] bv;
    core0 = -1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k > 0) inblk = 1;
      bv = 8'($urandom);
      in_valid = 1'b1;
      in_data  = bv;
      while (!in_ready) @(negedge clk);
      #1;
      if (k == 0) begin
        core0 = onehot_idx(core_in_valid);
        check(core0 == lowest_free(), "R2", core0, lowest_free());
      end else begin
        check(onehot_idx(core_in_valid) == core0, "R1", onehot_idx(core_in_valid), core0);
        if (k == 1) check(in_ready == 1'b1, "R9", in_ready, 1);
      end
      check(core_in_data == bv, "R1 data", core_in_data, bv);
      exp_q.push_back(bv ^ XK);
    end
    @(negedge clk);
    in_valid = 1'b0;
    inblk = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    inblk = 0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    obyte = 0;
    oblk = 0;
    rst = 1'b0;
    #1;
    check(in_ready == 1'b1, "R8 ready", in_ready, 1);
    check(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int lats[3];
    lats = '{99, 119, 139};
    for (int p = 0; p < 3; p++) begin
      lat = lats[p];
      do_reset();
      low_cnt = 0;
      streaming = 1;
      for (int b = 0; b < 24; b++) send_block();
      drain();
      streaming = 0;
      check(low_cnt == 0, "R6 no stall", low_cnt, 0);
      check(oblk == 24, "R4 block count", oblk, 24);
      // after draining, lowest-index choice returns to core 0
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h3A;
      #1;
      check(onehot_idx(core_in_valid) == 0, "R2 after drain", onehot_idx(core_in_valid), 0);
      in_valid = 1'b0;
      drain();
    end

    // Oversubscribed: delay too long for 11 cores
    lat = 300;
    do_reset();
    low_cnt = 0;
    for (int b = 0; b < 30; b++) send_block();
    check(low_cnt > 0, "R7 stall seen", low_cnt, 1);
    drain();
    check(oblk == 30, "R7 order after stall", oblk, 30);

    // Reset while cores hold blocks
    for (int b = 0; b < 5; b++) send_block();
    check(mbusy[0] == 1'b1, "R8 precondition", mbusy[0], 1);
    do_reset();
    repeat (400) begin
      @(negedge clk);
      #1;
      if (out_valid !== 1'b0) check(0, "R8 stale result", out_valid, 0);
    end
    check(out_valid == 1'b0, "R8 quiet", out_valid, 0);
    lat = 99;
    send_block();
    drain();
    check(oblk == 1, "R8 fresh block", oblk, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule